// File: doc/BRIEF.md
# Segment Selector Protection Checker

This block decides whether a segment selector and the descriptor it names may be loaded for a particular purpose, and reports the fault to raise if they may not. The caller presents the selector, the decoded descriptor fields, the current privilege level, the processor mode and a code that names the kind of load. One clock later the block returns a fault kind, the error code that goes with that fault, and a zero flag that marks a null selector.

Each check kind has its own rule set and its own fault priority. Examples are a far transfer to code, loading a stack segment, a return from interrupt, and loading the task register or the local descriptor table. All rule sets are evaluated side by side, and the check code selects one of them. The block does not fetch descriptors and does not check call gates; the surrounding pipeline does both. A check code outside the defined set raises its own illegal-code output and reports no fault.

Top module: `segchk_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output clears to 0. A check presented with `chk_valid` high at one edge shows its result, with `res_valid` high, after that edge. `res_valid` is low after any edge at which `chk_valid` was low.
- R2: A selector is null when its bits [15:2] are all zero. Those bits are the index [15:3] and the table bit [2], where a 1 means the local table. `zero_flag` is 1 when the selector is null and `zf_enable` is 1, and 0 in every other case, for every check code.
- R3: Code check (code 1): the descriptor is code when `dsc_nonsys`=1 and `dsc_type[3]`=1. A descriptor that is not code gives fault 1 (general protection, code 0). A code descriptor whose `dsc_dpl` differs from `cur_pl` also gives fault 1. Any other descriptor gives fault 0.
- R4: Software interrupt gate check (code 2): `dsc_dpl` < `cur_pl` gives fault 2 (general protection with the selector). Otherwise the result equals the R5 outcome.
- R5: Interrupt gate check (code 3): fault 1 if `dsc_type[2:1]` is not 2'b11. In long mode (`long_mode`=1), fault 1 also if `dsc_type[3:1]` is not 3'b111. Otherwise fault 0.
- R6: Stack check (code 4): a null selector gives fault 1. Otherwise, fault 2 if the RPL (`sel[1:0]`) differs from `cur_pl`, if `dsc_dpl` differs from `cur_pl`, or if the descriptor is not writable data. Writable data means `dsc_nonsys`=1, `dsc_type[3]`=0 and `dsc_type[1]`=1. Otherwise `dsc_present`=0 gives fault 4 (stack fault). Otherwise fault 0.
- R7: Interrupt return check (code 5): fault 2 in any of these cases: the selector is null; the RPL is below `cur_pl`; the descriptor is not code; `dsc_type[2]`=1 (conforming) and `dsc_dpl` > RPL; `dsc_type[2]`=0 and `dsc_dpl` differs from RPL. Otherwise `dsc_present`=0 gives fault 3 (not present). Otherwise fault 0.
- R8: Interrupt code segment check (code 6): fault 2 if the descriptor is not code or `dsc_dpl` > `cur_pl`. Otherwise `dsc_present`=0 gives fault 3. Otherwise fault 0.
- R9: Task register check (code 7): fault 2 if the selector is null or `sel[2]`=1. Otherwise fault 0.
- R10: Task state check (code 8): `dsc_present`=0 gives fault 3 first. Otherwise fault 2 unless `dsc_type` is 9, or `dsc_type` is 1 with `long_mode`=0. Otherwise fault 0.
- R11: Local table check (code 10): `dsc_present`=0 gives fault 3. Otherwise fault 2 unless `dsc_type` is 2. Otherwise fault 0.
- R12: Global table check (code 9): `sel[2]`=1 gives fault 2. Otherwise fault 0.
- R13: Code 0 gives fault 0 with `bad_kind`=0. Codes 11 to 15 give `bad_kind`=1 and fault 0. Every defined code gives `bad_kind`=0.
- R14: `err_code` is the selector with bits [1:0] cleared when the fault is 2, 3 or 4. It is 0 when the fault is 0 or 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| chk_valid | input | 1 | A check is presented this cycle |
| chk_kind | input | 4 | Check code (0..10 defined) |
| sel | input | SEL_W | Segment selector: index, table bit [2], RPL [1:0] |
| dsc_type | input | 4 | Descriptor type field |
| dsc_nonsys | input | 1 | 1 = code/data descriptor, 0 = system descriptor |
| dsc_dpl | input | PL_W | Descriptor privilege level |
| dsc_present | input | 1 | Descriptor present bit |
| cur_pl | input | PL_W | Current privilege level |
| long_mode | input | 1 | Processor is in long mode |
| zf_enable | input | 1 | Allow the null-selector zero flag |
| res_valid | output | 1 | Result of the previous cycle's check |
| fault | output | 3 | 0 none, 1 GP code 0, 2 GP selector, 3 not present, 4 stack fault |
| err_code | output | SEL_W | Error code for the reported fault |
| zero_flag | output | 1 | Null-selector flag |
| bad_kind | output | 1 | Check code was outside the defined set |

## Verification
Assertions watch properties that hold on every cycle. They cover the one-cycle result timing, the zero flag against the previous cycle's selector, the silence of an illegal code, a zero error code for faults without a selector, and the fixed outcomes of a null or local task-register selector and a local-table selector in the global check. The priority order inside each rule set can only be shown by the bench's scenarios. Examples are not-present against a wrong type, or a null selector against a privilege mismatch. The same holds for the mode-dependent task-state and gate types and for the conforming and non-conforming return rules. There, random and directed descriptors are compared against an independent model of the rules.

// File: rtl/segchk_pkg.sv
// Shared codes for the segment selector protection checker.
// Assumes a selector with the RPL in the low two bits and the table bit above it.
package segchk_pkg;
    localparam int TYPE_W = 4;

    typedef enum logic [3:0] {
        CK_NONE    = 4'd0,
        CK_CODE    = 4'd1,
        CK_SWGATE  = 4'd2,
        CK_IGATE   = 4'd3,
        CK_STACK   = 4'd4,
        CK_IRET    = 4'd5,
        CK_INTCS   = 4'd6,
        CK_TASKREG = 4'd7,
        CK_TSS     = 4'd8,
        CK_GLOBAL  = 4'd9,
        CK_LOCAL   = 4'd10
    } chk_kind_e;

    typedef enum logic [2:0] {
        FLT_NONE        = 3'd0,
        FLT_GP_ZERO     = 3'd1,
        FLT_GP_SEL      = 3'd2,
        FLT_NOT_PRESENT = 3'd3,
        FLT_STACK       = 3'd4
    } fault_e;
endpackage

// File: rtl/segchk_sel_fields.sv
// Splits a selector into the fields the rule sets use.
// Assumes bit 2 is the table bit and bits [1:0] the requested privilege.
module segchk_sel_fields #(
    parameter int SEL_W = 16,
    parameter int PL_W  = 2
) (
    input  logic [SEL_W-1:0] sel,
    output logic             is_null,
    output logic             table_local,
    output logic [PL_W-1:0]  rpl
);
    // Field extraction and null detection
    always_comb begin
        is_null     = (sel[SEL_W-1:PL_W] == '0);
        table_local = sel[PL_W];
        rpl         = sel[PL_W-1:0];
    end
endmodule

// File: rtl/segchk_code_rules.sv
// Rule sets that validate code and data segment descriptors: far code load,
// stack load, return from interrupt and interrupt handler code segment.
// Each output is the fault that rule set would raise, already prioritised.
module segchk_code_rules
    import segchk_pkg::*;
#(
    parameter int PL_W = 2
) (
    input  logic              is_null,
    input  logic [PL_W-1:0]   rpl,
    input  logic [TYPE_W-1:0] dsc_type,
    input  logic              dsc_nonsys,
    input  logic [PL_W-1:0]   dsc_dpl,
    input  logic              dsc_present,
    input  logic [PL_W-1:0]   cur_pl,
    output fault_e            f_code,
    output fault_e            f_stack,
    output fault_e            f_iret,
    output fault_e            f_intcs
);
    logic is_code;
    logic conforming;
    logic wr_data;
    logic iret_priv_bad;

    // Descriptor class decode
    always_comb begin
        is_code    = dsc_nonsys & dsc_type[3];
        conforming = dsc_type[2];
        wr_data    = dsc_nonsys & ~dsc_type[3] & dsc_type[1];
        iret_priv_bad = conforming ? (dsc_dpl > rpl) : (dsc_dpl != rpl);
    end

    // Far code load: class then exact privilege, both with a zero code
    always_comb begin
        if (!is_code)              f_code = FLT_GP_ZERO;
        else if (cur_pl != dsc_dpl) f_code = FLT_GP_ZERO;
        else                        f_code = FLT_NONE;
    end

    // Stack load: null, then privilege and class, then presence
    always_comb begin
        if (is_null)                                        f_stack = FLT_GP_ZERO;
        else if (rpl != cur_pl || dsc_dpl != cur_pl || !wr_data) f_stack = FLT_GP_SEL;
        else if (!dsc_present)                              f_stack = FLT_STACK;
        else                                                f_stack = FLT_NONE;
    end

    // Return from interrupt: any selector or privilege problem before presence
    always_comb begin
        if (is_null || rpl < cur_pl || !is_code || iret_priv_bad) f_iret = FLT_GP_SEL;
        else if (!dsc_present)                                    f_iret = FLT_NOT_PRESENT;
        else                                                      f_iret = FLT_NONE;
    end

    // Interrupt handler code segment: class and privilege before presence
    always_comb begin
        if (!is_code || dsc_dpl > cur_pl) f_intcs = FLT_GP_SEL;
        else if (!dsc_present)            f_intcs = FLT_NOT_PRESENT;
        else                              f_intcs = FLT_NONE;
    end
endmodule

// File: rtl/segchk_sys_rules.sv
// Rule sets for system descriptors and selector placement: gates, task
// register, task state, local table and global-table-only selectors.
module segchk_sys_rules
    import segchk_pkg::*;
#(
    parameter int PL_W = 2
) (
    input  logic              is_null,
    input  logic              table_local,
    input  logic [TYPE_W-1:0] dsc_type,
    input  logic [PL_W-1:0]   dsc_dpl,
    input  logic              dsc_present,
    input  logic [PL_W-1:0]   cur_pl,
    input  logic              long_mode,
    output fault_e            f_swgate,
    output fault_e            f_igate,
    output fault_e            f_taskreg,
    output fault_e            f_tss,
    output fault_e            f_global,
    output fault_e            f_local
);
    localparam logic [TYPE_W-1:0] TSS_WIDE   = 4'd9;
    localparam logic [TYPE_W-1:0] TSS_NARROW = 4'd1;
    localparam logic [TYPE_W-1:0] LDT_TYPE   = 4'd2;

    logic gate_bad;
    logic tss_ok;

    // Gate type qualification, stricter in long mode
    always_comb begin
        gate_bad = (dsc_type[2:1] != 2'b11) ||
                   (long_mode && dsc_type[3:1] != 3'b111);
        f_igate  = gate_bad ? FLT_GP_ZERO : FLT_NONE;
        f_swgate = (dsc_dpl < cur_pl) ? FLT_GP_SEL : f_igate;
    end

    // Selector placement rules
    always_comb begin
        f_taskreg = (is_null || table_local) ? FLT_GP_SEL : FLT_NONE;
        f_global  = table_local ? FLT_GP_SEL : FLT_NONE;
    end

    // Task state and local table descriptors: presence before type
    always_comb begin
        tss_ok = (dsc_type == TSS_WIDE) || (!long_mode && dsc_type == TSS_NARROW);
        if (!dsc_present) f_tss = FLT_NOT_PRESENT;
        else if (!tss_ok) f_tss = FLT_GP_SEL;
        else              f_tss = FLT_NONE;
        if (!dsc_present)             f_local = FLT_NOT_PRESENT;
        else if (dsc_type != LDT_TYPE) f_local = FLT_GP_SEL;
        else                          f_local = FLT_NONE;
    end
endmodule

// File: rtl/segchk_top.sv
// Segment selector protection checker. Evaluates every rule set in parallel,
// selects one by check code, forms the error code and registers the result.
// Assumes descriptor fields arrive already decoded in the same cycle.
module segchk_top
    import segchk_pkg::*;
#(
    parameter int SEL_W = 16,
    parameter int PL_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chk_valid,
    input  logic [3:0]       chk_kind,
    input  logic [SEL_W-1:0] sel,
    input  logic [3:0]       dsc_type,
    input  logic             dsc_nonsys,
    input  logic [PL_W-1:0]  dsc_dpl,
    input  logic             dsc_present,
    input  logic [PL_W-1:0]  cur_pl,
    input  logic             long_mode,
    input  logic             zf_enable,
    output logic             res_valid,
    output logic [2:0]       fault,
    output logic [SEL_W-1:0] err_code,
    output logic             zero_flag,
    output logic             bad_kind
);
    logic            is_null;
    logic            table_local;
    logic [PL_W-1:0] rpl;
    fault_e f_code, f_stack, f_iret, f_intcs;
    fault_e f_swgate, f_igate, f_taskreg, f_tss, f_global, f_local;
    fault_e          pick;
    logic            illegal;
    logic [SEL_W-1:0] err_next;

    segchk_sel_fields #(.SEL_W(SEL_W), .PL_W(PL_W)) u_fields (
        .sel(sel), .is_null(is_null), .table_local(table_local), .rpl(rpl)
    );

    segchk_code_rules #(.PL_W(PL_W)) u_code (
        .is_null(is_null), .rpl(rpl), .dsc_type(dsc_type),
        .dsc_nonsys(dsc_nonsys), .dsc_dpl(dsc_dpl), .dsc_present(dsc_present),
        .cur_pl(cur_pl), .f_code(f_code), .f_stack(f_stack),
        .f_iret(f_iret), .f_intcs(f_intcs)
    );

    segchk_sys_rules #(.PL_W(PL_W)) u_sys (
        .is_null(is_null), .table_local(table_local), .dsc_type(dsc_type),
        .dsc_dpl(dsc_dpl), .dsc_present(dsc_present), .cur_pl(cur_pl),
        .long_mode(long_mode), .f_swgate(f_swgate), .f_igate(f_igate),
        .f_taskreg(f_taskreg), .f_tss(f_tss), .f_global(f_global),
        .f_local(f_local)
    );

    // Select the rule set named by the check code
    always_comb begin
        pick    = FLT_NONE;
        illegal = 1'b0;
        case (chk_kind)
            CK_NONE:    pick = FLT_NONE;
            CK_CODE:    pick = f_code;
            CK_SWGATE:  pick = f_swgate;
            CK_IGATE:   pick = f_igate;
            CK_STACK:   pick = f_stack;
            CK_IRET:    pick = f_iret;
            CK_INTCS:   pick = f_intcs;
            CK_TASKREG: pick = f_taskreg;
            CK_TSS:     pick = f_tss;
            CK_GLOBAL:  pick = f_global;
            CK_LOCAL:   pick = f_local;
            default:    illegal = 1'b1;
        endcase
    end

    // Error code: selector without RPL for selector-carrying faults
    always_comb begin
        if (pick == FLT_GP_SEL || pick == FLT_NOT_PRESENT || pick == FLT_STACK)
            err_next = {sel[SEL_W-1:PL_W], {PL_W{1'b0}}};
        else
            err_next = '0;
    end

    // Result register, loaded on each presented check
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            fault     <= '0;
            err_code  <= '0;
            zero_flag <= 1'b0;
            bad_kind  <= 1'b0;
        end else begin
            res_valid <= chk_valid;
            if (chk_valid) begin
                fault     <= pick;
                err_code  <= err_next;
                zero_flag <= zf_enable & is_null;
                bad_kind  <= illegal;
            end
        end
    end

    AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |=> res_valid); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |=> !res_valid); // R1
    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |=> (zero_flag == $past(zf_enable && sel[SEL_W-1:PL_W] == '0))); // R2
    AST_TASKREG_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && chk_kind == CK_TASKREG && (sel[SEL_W-1:PL_W] == '0 || sel[PL_W]))
        |=> fault == FLT_GP_SEL); // R9
    AST_GLOBAL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && chk_kind == CK_GLOBAL && sel[PL_W]) |=> fault == FLT_GP_SEL); // R12
    AST_BAD_KIND_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && bad_kind) |-> fault == FLT_NONE); // R13
    AST_ZERO_ERRCODE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && (fault == FLT_NONE || fault == FLT_GP_ZERO)) |-> err_code == '0); // R14
endmodule

// File: tb/segchk_top_test.sv
module segchk_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chk_valid = 1'b0;
    logic [3:0]  chk_kind = '0;
    logic [15:0] sel = '0;
    logic [3:0]  dsc_type = '0;
    logic        dsc_nonsys = 1'b0;
    logic [1:0]  dsc_dpl = '0;
    logic        dsc_present = 1'b0;
    logic [1:0]  cur_pl = '0;
    logic        long_mode = 1'b0;
    logic        zf_enable = 1'b0;
    logic        res_valid;
    logic [2:0]  fault;
    logic [15:0] err_code;
    logic        zero_flag;
    logic        bad_kind;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    segchk_top uut (
        .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .chk_kind(chk_kind),
        .sel(sel), .dsc_type(dsc_type), .dsc_nonsys(dsc_nonsys),
        .dsc_dpl(dsc_dpl), .dsc_present(dsc_present), .cur_pl(cur_pl),
        .long_mode(long_mode), .zf_enable(zf_enable), .res_valid(res_valid),
        .fault(fault), .err_code(err_code), .zero_flag(zero_flag),
        .bad_kind(bad_kind)
    );

    always #5 clk = ~clk;

    function automatic string req_of(input logic [3:0] k);
        case (k)
            4'd1: return "R3";   4'd2: return "R4";   4'd3: return "R5";
            4'd4: return "R6";   4'd5: return "R7";   4'd6: return "R8";
            4'd7: return "R9";   4'd8: return "R10";  4'd9: return "R12";
            4'd10: return "R11";
            default: return "R13";
        endcase
    endfunction

    // Independent model of the requirement rules
    function automatic logic [2:0] model(input logic [3:0] k, input logic [15:0] s,
        input logic [3:0] t, input logic ns, input logic [1:0] d, input logic p,
        input logic [1:0] c, input logic lm);
        logic nul, loc, code, conf, wd;
        logic [1:0] r;
        nul  = (s[15:3] == 0) && !s[2];
        loc  = s[2];
        r    = s[1:0];
        code = ns && t[3];
        conf = t[2];
        wd   = ns && !t[3] && t[1];
        case (k)
            4'd1: return (!code || d != c) ? 3'd1 : 3'd0;
            4'd2, 4'd3: begin
                if (k == 4'd2 && d < c) return 3'd2;
                if (!(t[2] && t[1])) return 3'd1;
                if (lm && !(t[3] && t[2] && t[1])) return 3'd1;
                return 3'd0;
            end
            4'd4: begin
                if (nul) return 3'd1;
                if (r != c || d != c || !wd) return 3'd2;
                return p ? 3'd0 : 3'd4;
            end
            4'd5: begin
                if (nul || r < c || !code) return 3'd2;
                if (conf && d > r) return 3'd2;
                if (!conf && d != r) return 3'd2;
                return p ? 3'd0 : 3'd3;
            end
            4'd6: begin
                if (!code || d > c) return 3'd2;
                return p ? 3'd0 : 3'd3;
            end
            4'd7: return (nul || loc) ? 3'd2 : 3'd0;
            4'd8: begin
                if (!p) return 3'd3;
                if (t == 4'd9 || (t == 4'd1 && !lm)) return 3'd0;
                return 3'd2;
            end
            4'd9: return loc ? 3'd2 : 3'd0;
            4'd10: begin
                if (!p) return 3'd3;
                return (t == 4'd2) ? 3'd0 : 3'd2;
            end
            default: return 3'd0;
        endcase
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_one(input logic [3:0] k, input logic [15:0] s, input logic [3:0] t,
        input logic ns, input logic [1:0] d, input logic p, input logic [1:0] c,
        input logic lm, input logic zf);
        logic [2:0] ef;
        logic [15:0] ee;
        @(negedge clk);
        chk_valid = 1'b1; chk_kind = k; sel = s; dsc_type = t; dsc_nonsys = ns;
        dsc_dpl = d; dsc_present = p; cur_pl = c; long_mode = lm; zf_enable = zf;
        ef = model(k, s, t, ns, d, p, c, lm);
        ee = (ef >= 3'd2) ? {s[15:2], 2'b00} : 16'h0;
        @(negedge clk);
        check("R1", "res_valid", 32'(res_valid), 32'd1);
        check(req_of(k), "fault", 32'(fault), 32'(ef));
        check("R14", "err_code", 32'(err_code), 32'(ee));
        check("R2", "zero_flag", 32'(zero_flag), 32'(zf && s[15:2] == 0));
        check("R13", "bad_kind", 32'(bad_kind), 32'(k > 4'd10));
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1", "reset res_valid", 32'(res_valid), 32'd0);
        check("R1", "reset fault", 32'(fault), 32'd0);
        check("R1", "reset zero_flag", 32'(zero_flag), 32'd0);
        rst_n = 1'b1;

        // R3 code: pass, system desc, privilege mismatch
        run_one(4'd1, 16'h0010, 4'hA, 1, 2'd0, 1, 2'd0, 0, 1);
        run_one(4'd1, 16'h0010, 4'hA, 0, 2'd0, 1, 2'd0, 0, 1);
        run_one(4'd1, 16'h0010, 4'hA, 1, 2'd3, 1, 2'd0, 0, 1);
        // R4 software gate: privilege fail, pass
        run_one(4'd2, 16'h0023, 4'hE, 0, 2'd0, 1, 2'd3, 0, 0);
        run_one(4'd2, 16'h0023, 4'hE, 0, 2'd3, 1, 2'd3, 0, 0);
        // R5 interrupt gate: legacy 6 passes, long mode 6 fails, long 14 passes
        run_one(4'd3, 16'h0008, 4'h6, 0, 2'd0, 1, 2'd0, 0, 0);
        run_one(4'd3, 16'h0008, 4'h6, 0, 2'd0, 1, 2'd0, 1, 0);
        run_one(4'd3, 16'h0008, 4'hE, 0, 2'd0, 1, 2'd0, 1, 0);
        run_one(4'd3, 16'h0008, 4'h4, 0, 2'd0, 1, 2'd0, 0, 0);
        // R6 stack: null, pass, not present, bad rpl
        run_one(4'd4, 16'h0003, 4'h2, 1, 2'd3, 1, 2'd3, 0, 1);
        run_one(4'd4, 16'h002B, 4'h2, 1, 2'd3, 1, 2'd3, 0, 1);
        run_one(4'd4, 16'h002B, 4'h2, 1, 2'd3, 0, 2'd3, 0, 1);
        run_one(4'd4, 16'h0029, 4'h2, 1, 2'd3, 1, 2'd3, 0, 1);
        // R7 return: conforming pass, non-conforming mismatch, not present, null
        run_one(4'd5, 16'h0033, 4'hE, 1, 2'd1, 1, 2'd0, 0, 0);
        run_one(4'd5, 16'h0033, 4'hA, 1, 2'd1, 1, 2'd0, 0, 0);
        run_one(4'd5, 16'h0033, 4'hA, 1, 2'd3, 0, 2'd0, 0, 0);
        run_one(4'd5, 16'h0000, 4'hA, 1, 2'd0, 1, 2'd0, 0, 1);
        // R8 interrupt code segment: pass, dpl above cpl, not present
        run_one(4'd6, 16'h0010, 4'hA, 1, 2'd0, 1, 2'd2, 0, 0);
        run_one(4'd6, 16'h0010, 4'hA, 1, 2'd3, 1, 2'd2, 0, 0);
        run_one(4'd6, 16'h0010, 4'hA, 1, 2'd0, 0, 2'd2, 0, 0);
        // R9 task register: pass, null, local
        run_one(4'd7, 16'h0040, 4'h9, 0, 2'd0, 1, 2'd0, 0, 1);
        run_one(4'd7, 16'h0001, 4'h9, 0, 2'd0, 1, 2'd0, 0, 1);
        run_one(4'd7, 16'h0044, 4'h9, 0, 2'd0, 1, 2'd0, 0, 1);
        // R10 task state: not present wins over bad type, type 1 by mode
        run_one(4'd8, 16'h0048, 4'h5, 0, 2'd0, 0, 2'd0, 0, 0);
        run_one(4'd8, 16'h0048, 4'h1, 0, 2'd0, 1, 2'd0, 0, 0);
        run_one(4'd8, 16'h0048, 4'h1, 0, 2'd0, 1, 2'd0, 1, 0);
        run_one(4'd8, 16'h0048, 4'h9, 0, 2'd0, 1, 2'd0, 1, 0);
        // R12 global only
        run_one(4'd9, 16'h0050, 4'h0, 0, 2'd0, 1, 2'd0, 0, 0);
        run_one(4'd9, 16'h0054, 4'h0, 0, 2'd0, 1, 2'd0, 0, 0);
        // R11 local table: pass, wrong type, not present
        run_one(4'd10, 16'h0058, 4'h2, 0, 2'd0, 1, 2'd0, 0, 0);
        run_one(4'd10, 16'h0058, 4'h3, 0, 2'd0, 1, 2'd0, 0, 0);
        run_one(4'd10, 16'h0058, 4'h3, 0, 2'd0, 0, 2'd0, 0, 0);
        // R13 none code and illegal codes
        run_one(4'd0, 16'h0000, 4'h0, 0, 2'd0, 0, 2'd0, 0, 1);
        run_one(4'd11, 16'h0004, 4'h0, 0, 2'd0, 0, 2'd0, 0, 0);
        run_one(4'd15, 16'h0000, 4'h0, 0, 2'd0, 0, 2'd0, 0, 1);

        // R1 idle cycle drops res_valid
        @(negedge clk);
        chk_valid = 1'b0;
        @(negedge clk);
        check("R1", "idle res_valid", 32'(res_valid), 32'd0);

        // Random mix over every code
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] s;
            s = 16'($urandom());
            if ($urandom_range(0, 3) == 0) s[15:2] = '0;
            run_one(4'($urandom_range(0, 15)), s, 4'($urandom()), 1'($urandom()),
                    2'($urandom()), 1'($urandom_range(0, 3) != 0), 2'($urandom()),
                    1'($urandom()), 1'($urandom()));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule